// File: doc/BRIEF.md
# Byte-Stream Hamming Parity Generator

This block sits beside the data path of a flash controller. It builds a single-error-correcting Hamming code over every 256-byte chunk of page data, whether that data is going to the flash or coming back from it. A byte enters on each clock where the strobe and the enable are both high. The block keeps column parity over the bit positions and line parity over the byte index. When the last byte of a chunk has been taken in, it latches the packed result. It then starts the next chunk at once, so no idle cycle is needed between chunks.

Two forms of the result are presented. The first is the raw word. The second is the 24-bit form that is written into the spare area: the raw word is shifted up by two places and inverted, and its bytes are sent high byte first. A one-cycle flag marks each completed chunk. A synchronous clear empties the running parity before a new page begins. Spare-area bytes are kept out of the code by holding the enable low while they pass.

Top module: `ecc256_gen`

## Requirements
- R1: While reset is low and on the first cycle after it, `ecc_raw` is 0, `ecc_stored` is 24'hFFFFFF and `chunk_done` is 0.
- R2: `ecc_raw[5:0]` holds the column parity of the chunk. For k in 0..2, bit 2k+1 is the XOR of all data bits whose bit position has bit k set. Bit 2k is the XOR of all data bits whose bit position has bit k clear.
- R3: `ecc_raw[21:6]` holds the line parity. For k in 0..7, raw bit 6+2k+1 is the XOR of the byte parities of all bytes whose index in the chunk (0..255, in arrival order) has bit k set. Raw bit 6+2k covers the bytes whose index has bit k clear.
- R4: `ecc_stored` equals the bitwise inverse of `{ecc_raw, 2'b00}`. Its byte for the first flash location is bits 23:16, then 15:8, then 7:0, and bits 1:0 are always 1.
- R5: `chunk_done` is high for exactly one cycle: the cycle after the clock edge that takes in the 256th byte of a chunk. `ecc_raw` shows the new result in that same cycle.
- R6: A byte taken in on the edge right after a chunk's last byte counts as byte 0 of the next chunk. Chunks may run back to back with no gap.
- R7: `ecc_raw` changes only at a chunk completion. It holds between completions, including through idle cycles.
- R8: A byte presented with `en` low or `byte_vld` low has no effect on the parity or on the byte position.
- R9: `clr` high restarts the chunk. The parity is emptied and the byte position returns to 0. A byte offered in the same cycle is discarded. `ecc_raw` is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous restart of the running chunk |
| en | input | 1 | Accumulation enable; low for bytes outside the coded area |
| byte_vld | input | 1 | A byte is present on `byte_in` |
| byte_in | input | 8 | Data byte |
| ecc_raw | output | 22 | Latched result: line parity 21:6, column parity 5:0 |
| ecc_stored | output | 24 | Inverted, shifted form for the spare area |
| chunk_done | output | 1 | One-cycle pulse when a new result is latched |

## Verification
A byte driven before an edge reaches the running parity at that edge. If it is the 256th byte, `ecc_raw`, `ecc_stored` and `chunk_done` all show the new value one register later, in the next cycle. The bench drives on the falling edge and checks the completion outputs at the very next falling edge. It does this before it drives the following byte, so a back-to-back chunk is checked in the same cycle its first byte enters. Holding behaviour is checked mid-chunk, after gaps of disabled bytes, and in the cycle that follows a clear, where a wrongly counted byte or a disturbed result would first show.

// File: rtl/ecc256_pkg.sv
// Package: default geometry shared by the parity generator and its parts.
// Assumes one result per chunk of ECC_CHUNK bytes of ECC_DATA_W bits.
package ecc256_pkg;
    localparam int unsigned ECC_DATA_W = 8;
    localparam int unsigned ECC_CHUNK  = 256;
endpackage

// File: rtl/ecc_byte_ctr.sv
// Module: position of the next byte inside the current chunk.
// Flags the accepted byte that closes a chunk. Assumes CHUNK is a power of two,
// so the counter wraps to 0 on its own after the last byte.
module ecc_byte_ctr #(
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    // last byte of a chunk: accepted, not cancelled by a clear, at top index
    assign last = step && !clr && (&idx);

    // advance on each accepted byte; clear or reset returns to position 0
    always_ff @(posedge clk) begin
        if (!rst_n || clr) idx <= '0;
        else if (step)     idx <= idx + 1'b1;
    end

    AST_CLR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (idx == '0)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(idx)); // R8
    AST_STEP_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> (idx == IDX_W'($past(idx) + 1'b1))); // R6
endmodule

// File: rtl/ecc_col_acc.sv
// Module: running column parity over bit positions of each byte.
// Pair k holds the XOR of the bits whose position has bit k clear (even slot)
// and set (odd slot). col_next includes the byte on the input this cycle.
module ecc_col_acc #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned POS_W = $clog2(DATA_W),
    localparam int unsigned COL_W = 2 * POS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  logic [DATA_W-1:0] din,
    output logic [COL_W-1:0]  col_next
);
    logic [COL_W-1:0] col_q;
    logic [COL_W-1:0] col_par;

    // mask of bit positions whose index has bit k set
    function automatic logic [DATA_W-1:0] hi_mask(input int unsigned k);
        logic [DATA_W-1:0] m;
        for (int unsigned b = 0; b < DATA_W; b++) m[b] = ((b >> k) & 1) != 0;
        return m;
    endfunction

    genvar k;
    generate
        for (k = 0; k < POS_W; k++) begin : g_pair
            assign col_par[2*k+1] = ^(din & hi_mask(k));
            assign col_par[2*k]   = ^(din & ~hi_mask(k));
        end
    endgenerate

    // fold the current byte into the running value when it is accepted
    assign col_next = col_q ^ (step ? col_par : '0);

    // hold running value; empty it on reset or chunk restart
    always_ff @(posedge clk) begin
        if (!rst_n || restart) col_q <= '0;
        else                   col_q <= col_next;
    end
endmodule

// File: rtl/ecc_line_acc.sv
// Module: running line parity over the byte index within the chunk.
// For address bit k, the odd slot collects byte parities at indices with bit k
// set and the even slot those with bit k clear.
module ecc_line_acc #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned IDX_W  = 8,
    localparam int unsigned LINE_W = 2 * IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  logic [DATA_W-1:0] din,
    input  logic [IDX_W-1:0]  idx,
    output logic [LINE_W-1:0] line_next
);
    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] contrib;
    logic              bpar;

    assign bpar = ^din;

    genvar k;
    generate
        for (k = 0; k < IDX_W; k++) begin : g_addr
            assign contrib[2*k+1] = step & bpar & idx[k];
            assign contrib[2*k]   = step & bpar & ~idx[k];
        end
    endgenerate

    assign line_next = line_q ^ contrib;

    // hold running value; empty it on reset or chunk restart
    always_ff @(posedge clk) begin
        if (!rst_n || restart) line_q <= '0;
        else                   line_q <= line_next;
    end
endmodule

// File: rtl/ecc256_gen.sv
// Module: chunked Hamming parity generator for a flash data stream.
// Takes one byte per cycle when en and byte_vld are high. Latches
// {line, column} parity after each CHUNK_BYTES bytes and restarts with no gap.
// Assumes CHUNK_BYTES and DATA_W are powers of two.
module ecc256_gen
    import ecc256_pkg::*;
#(
    parameter int unsigned DATA_W      = ECC_DATA_W,
    parameter int unsigned CHUNK_BYTES = ECC_CHUNK,
    localparam int unsigned IDX_W   = $clog2(CHUNK_BYTES),
    localparam int unsigned COL_W   = 2 * $clog2(DATA_W),
    localparam int unsigned LINE_W  = 2 * IDX_W,
    localparam int unsigned RAW_W   = COL_W + LINE_W,
    localparam int unsigned STORE_W = RAW_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic               byte_vld,
    input  logic [DATA_W-1:0]  byte_in,
    output logic [RAW_W-1:0]   ecc_raw,
    output logic [STORE_W-1:0] ecc_stored,
    output logic               chunk_done
);
    logic              take;
    logic              acc_step;
    logic              restart;
    logic              last;
    logic [IDX_W-1:0]  idx;
    logic [COL_W-1:0]  col_next;
    logic [LINE_W-1:0] line_next;

    assign take     = en && byte_vld;
    assign acc_step = take && !clr;
    assign restart  = clr || last;

    ecc_byte_ctr #(.IDX_W(IDX_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step(take),
        .idx(idx), .last(last)
    );

    ecc_col_acc #(.DATA_W(DATA_W)) u_col (
        .clk(clk), .rst_n(rst_n), .restart(restart), .step(acc_step),
        .din(byte_in), .col_next(col_next)
    );

    ecc_line_acc #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_line (
        .clk(clk), .rst_n(rst_n), .restart(restart), .step(acc_step),
        .din(byte_in), .idx(idx), .line_next(line_next)
    );

    // latch the finished chunk result and raise the one-cycle done flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecc_raw    <= '0;
            chunk_done <= 1'b0;
        end else begin
            chunk_done <= last;
            if (last) ecc_raw <= {line_next, col_next};
        end
    end

    // spare-area form: shifted up two places and inverted
    assign ecc_stored = ~{ecc_raw, 2'b00};

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> chunk_done); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_done |=> !chunk_done); // R5
    AST_RAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !chunk_done |-> $stable(ecc_raw)); // R7
    AST_STORED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_stored[1:0] == 2'b11); // R4
endmodule

// File: tb/sim_ecc256_gen.sv
`timescale 1ns/1ps
module sim_ecc256_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        en = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = '0;
    logic [21:0] ecc_raw;
    logic [23:0] ecc_stored;
    logic        chunk_done;

    always #2 clk = ~clk;

    ecc256_gen u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .byte_vld(byte_vld),
        .byte_in(byte_in), .ecc_raw(ecc_raw), .ecc_stored(ecc_stored),
        .chunk_done(chunk_done)
    );

    int          checks = 0;
    int          errors = 0;
    bit          finished = 0;
    bit          pending = 0;
    string       pend_tag = "";
    logic [21:0] exp_raw = '0;
    logic [21:0] last_raw = '0;
    logic [7:0]  chunk [256];
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [21:0] ref_raw();
        logic [5:0]  c = '0;
        logic [15:0] l = '0;
        for (int i = 0; i < 256; i++)
            for (int b = 0; b < 8; b++)
                if (chunk[i][b]) begin
                    for (int k = 0; k < 3; k++) c[2*k + ((b >> k) & 1)] ^= 1'b1;
                    for (int k = 0; k < 8; k++) l[2*k + ((i >> k) & 1)] ^= 1'b1;
                end
        return {l, c};
    endfunction

    function automatic logic [7:0] next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[7:0] ^ lfsr[15:8];
    endfunction

    task automatic check_result();
        logic [23:0] st;
        st = ~{exp_raw, 2'b00};
        chk({pend_tag, " R5 done"}, {31'd0, chunk_done}, 32'd1);
        chk({pend_tag, " R2 column"}, {26'd0, ecc_raw[5:0]}, {26'd0, exp_raw[5:0]});
        chk({pend_tag, " R3 line"}, {16'd0, ecc_raw[21:6]}, {16'd0, exp_raw[21:6]});
        chk({pend_tag, " R4 stored"}, {8'd0, ecc_stored}, {8'd0, st});
        chk({pend_tag, " R4 first byte"}, {24'd0, ecc_stored[23:16]}, {24'd0, st[23:16]});
        last_raw = exp_raw;
        pending = 0;
    endtask

    // falling edge: check any completed chunk, then drive the next inputs
    task automatic drive(input logic e, input logic v, input logic [7:0] d, input logic c);
        @(negedge clk);
        if (pending) check_result();
        en = e; byte_vld = v; byte_in = d; clr = c;
    endtask

    task automatic send_chunk(input string tag, input bit gaps);
        for (int i = 0; i < 256; i++) begin
            if (i == 128) begin
                @(negedge clk);
                chk({tag, " R5 no done mid-chunk"}, {31'd0, chunk_done}, 32'd0);
                chk({tag, " R7 hold mid-chunk"}, {10'd0, ecc_raw}, {10'd0, last_raw});
                en = 1'b0; byte_vld = 1'b0;
            end
            if (gaps && (i % 3 == 0)) begin
                drive(1'b0, 1'b1, next_rand(), 1'b0);
                drive(1'b1, 1'b0, next_rand(), 1'b0);
            end
            drive(1'b1, 1'b1, chunk[i], 1'b0);
        end
        exp_raw = ref_raw();
        pend_tag = tag;
        pending = 1;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 raw in reset", {10'd0, ecc_raw}, 32'd0);
        chk("R1 stored in reset", {8'd0, ecc_stored}, 32'h00FFFFFF);
        chk("R1 done in reset", {31'd0, chunk_done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 raw after reset", {10'd0, ecc_raw}, 32'd0);

        // single set bit walked over every byte position, chunks back to back
        for (int p = 0; p < 256; p++) begin
            for (int i = 0; i < 256; i++) chunk[i] = 8'h00;
            chunk[p] = 8'h01 << (p % 8);
            send_chunk("R6 walk", 1'b0);
        end
        // dense pseudo-random chunks back to back
        for (int n = 0; n < 3; n++) begin
            for (int i = 0; i < 256; i++) chunk[i] = next_rand();
            send_chunk("R6 random", 1'b0);
        end
        drive(1'b0, 1'b0, 8'h00, 1'b0);
        repeat (5) drive(1'b0, 1'b1, 8'hFF, 1'b0);
        @(negedge clk);
        chk("R7 hold while idle", {10'd0, ecc_raw}, {10'd0, last_raw});
        chk("R8 idle no done", {31'd0, chunk_done}, 32'd0);

        // disabled and invalid bytes interleaved with the real ones
        for (int i = 0; i < 256; i++) chunk[i] = next_rand();
        send_chunk("R8 gaps", 1'b1);
        drive(1'b0, 1'b0, 8'h00, 1'b0);

        // partial chunk, then a clear with a byte offered at the same time
        for (int i = 0; i < 100; i++) drive(1'b1, 1'b1, next_rand(), 1'b0);
        drive(1'b1, 1'b1, 8'h5A, 1'b1);
        @(negedge clk);
        chk("R9 raw kept on clear", {10'd0, ecc_raw}, {10'd0, last_raw});
        chk("R9 no done on clear", {31'd0, chunk_done}, 32'd0);
        clr = 1'b0; en = 1'b0; byte_vld = 1'b0;
        for (int i = 0; i < 256; i++) chunk[i] = next_rand();
        send_chunk("R9 after clear", 1'b0);
        drive(1'b0, 1'b0, 8'h00, 1'b0);
        @(negedge clk);
        chk("R5 single-cycle done", {31'd0, chunk_done}, 32'd0);

        finished = 1;
        summary();
        $finish;
    end
endmodule